// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 72 level-sensitive interrupt lines into one processor interrupt request. Sixty-four lines arrive in two 32-bit peripheral banks, named bank A and bank B. Eight more arrive as a small group of basic lines. Every line has its own mask bit. Software sets mask bits through one address per group and clears them through a separate address. A write of 1 acts on a bit and a write of 0 leaves it alone, so no read-modify-write is needed and two agents cannot race on a shared mask.

Software reads a single summary word to find out what is active. That word holds the masked basic lines, one "anything active" flag per peripheral bank, and direct copies of a few chosen bank lines. A handler for the most common sources can therefore finish after one read. For the others it reads the masked pending word of the flagged bank. Nothing is latched: every pending bit follows its input line. The interrupt output is the OR of every masked line, passed through one register.

The register port is a plain 32-bit interface. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all 72 mask bits are 0, the summary word reads 0 and `irq` is 0, whatever the input lines are doing.
- R2: A write to a mask-set address sets the mask bits of that group where the written data is 1 and leaves the other bits unchanged. The set addresses are 0x10 (bank A), 0x14 (bank B) and 0x18 (basic, data bits 7:0), that is 0x10 plus 4 times the group index.
- R3: A write to a mask-clear address clears the mask bits where the data is 1 and leaves the other bits unchanged. The clear addresses are 0x20 (bank A), 0x24 (bank B) and 0x28 (basic).
- R4: A read of either the set address or the clear address of a group returns that group's current mask, zero-extended to 32 bits.
- R5: The pending word of bank A (address 0x04) and of bank B (address 0x08) reads as the bank's input lines ANDed with its mask. It follows the inputs in the same cycle and holds no memory of a line that has since dropped.
- R6: Summary word (address 0x00) bits 7:0 are the basic input lines ANDed with the basic mask.
- R7: Summary bit 8 is 1 exactly when some masked line of bank A is active. Summary bit 9 is 1 exactly when some masked line of bank B is active.
- R8: Summary bits 14:10 are copies of the masked bank-A lines 3, 7, 9, 18 and 19, in that order from bit 10 upward. Bits 20:15 are copies of the masked bank-B lines 21, 22, 23, 24, 25 and 30, in that order from bit 15 upward.
- R9: Summary bits 31:21 always read 0. The summary word is 0 exactly when no masked line is active.
- R10: `irq` is 1 in the cycle after a clock edge at which any masked line was active, and 0 in the cycle after an edge at which none was active. Its latency is one clock.
- R11: Writes to the summary address, to the pending addresses or to unmapped addresses change no mask bit. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_bank | input | 64 | Peripheral lines; bits 31:0 are bank A, bits 63:32 are bank B |
| src_basic | input | 8 | Basic interrupt lines |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
Most state lives in the mask bits. A wrong mask bit shows at the ports straight away on a read of the group's set or clear address. It also shows as soon as the matching input line goes active: the line then appears in, or is missing from, the bank pending word, the bank flag and any shortcut bit in the same cycle, and `irq` differs one edge later. The only other register is the `irq` flop. A stale or latched value there shows up within one cycle as a mismatch against the summary word. The vector walk therefore chooses masks and inputs so that enabled and disabled lines in every summary field are each driven both ways.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared sizes, register offsets and summary-word layout for the banked
// interrupt controller. Assumes two peripheral banks and one basic group.
package irqc_pkg;
    localparam int unsigned BANK_W    = 32;
    localparam int unsigned N_PERIPH  = 2;
    localparam int unsigned BASIC_W   = 8;
    localparam int unsigned N_GRP     = N_PERIPH + 1;
    localparam int unsigned DATA_W    = 32;

    // Byte offsets; mask set/clear sit at base + 4 * group index.
    localparam int unsigned OFF_SUMMARY = 'h00;
    localparam int unsigned OFF_PEND    = 'h04;
    localparam int unsigned OFF_ENSET   = 'h10;
    localparam int unsigned OFF_ENCLR   = 'h20;

    // Shortcut selections copied into the summary word.
    localparam int unsigned N_SC_A = 5;
    localparam int unsigned N_SC_B = 6;
    localparam int unsigned SC_A_IDX [N_SC_A] = '{3, 7, 9, 18, 19};
    localparam int unsigned SC_B_IDX [N_SC_B] = '{21, 22, 23, 24, 25, 30};

    // Summary-word bit positions derived from the sizes above.
    localparam int unsigned SUM_FLAG_A = BASIC_W;
    localparam int unsigned SUM_FLAG_B = BASIC_W + 1;
    localparam int unsigned SUM_SC_A   = BASIC_W + 2;
    localparam int unsigned SUM_SC_B   = SUM_SC_A + N_SC_A;
    localparam int unsigned SUM_USED   = SUM_SC_B + N_SC_B;
endpackage

// File: rtl/irqc_enable_reg.sv
// Module irqc_enable_reg
// One group of mask bits, updated by write-one-to-set and write-one-to-clear
// strobes. Assumes the two strobes are never high in the same cycle (they
// decode distinct addresses); if they were, set would win.
module irqc_enable_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);

    // Mask bit update: reset to zero, OR in on set, AND-NOT on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we) begin
            en_q <= en_q | wdata;
        end else if (clr_we) begin
            en_q <= en_q & ~wdata;
        end
    end

    // R1: the first cycle out of reset sees an empty mask.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> en_q == '0);

    // R2: every bit written as 1 to the set address is 1 afterwards.
    a_r2_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (en_q & $past(wdata)) == $past(wdata));

    // R3: every bit written as 1 to the clear address is 0 afterwards.
    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (en_q & $past(wdata)) == '0);

    // R2/R3: bits written as 0 keep their value.
    a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> ((en_q ^ $past(en_q)) & ~$past(wdata)) == '0);

    // R11: with no strobe for this group the mask holds.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en_q));

endmodule

// File: rtl/irqc_summary.sv
// Module irqc_summary
// Builds the summary word from masked basic lines and the masked pending
// words of the two peripheral banks. Purely combinational; assumes inputs
// are already ANDed with their masks.
module irqc_summary
    import irqc_pkg::*;
#(
    parameter int unsigned BW = BANK_W,
    parameter int unsigned SW = BASIC_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] basic_m,
    input  logic [BW-1:0] pend_a,
    input  logic [BW-1:0] pend_b,
    output logic [DW-1:0] summary
);

    // Assemble basic field, bank flags and shortcut copies; rest stays 0.
    always_comb begin
        summary = '0;
        summary[SW-1:0]    = basic_m;
        summary[SUM_FLAG_A] = |pend_a;
        summary[SUM_FLAG_B] = |pend_b;
        for (int k = 0; k < N_SC_A; k++) begin
            summary[SUM_SC_A + k] = pend_a[SC_A_IDX[k]];
        end
        for (int k = 0; k < N_SC_B; k++) begin
            summary[SUM_SC_B + k] = pend_b[SC_B_IDX[k]];
        end
    end

    // R8: any bank-A shortcut bit implies the bank-A flag.
    a_r8_short_a_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|summary[SUM_SC_B-1:SUM_SC_A]) |-> summary[SUM_FLAG_A]);

    // R8: any bank-B shortcut bit implies the bank-B flag.
    a_r8_short_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|summary[SUM_USED-1:SUM_SC_B]) |-> summary[SUM_FLAG_B]);

    // R9: a zero summary means no masked line anywhere.
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (summary == '0) == ((basic_m == '0) && (pend_a == '0) && (pend_b == '0)));

    // R9: upper bits are never set.
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        summary[DW-1:SUM_USED] == '0);

endmodule

// File: rtl/irqc_regif.sv
// Module irqc_regif
// Address decode for mask set/clear strobes and the combinational read mux.
// Assumes byte addresses on word boundaries; other addresses read as zero.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned BW = BANK_W,
    parameter int unsigned NG = N_GRP,
    parameter int unsigned NP = N_PERIPH
) (
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [NG-1:0][DW-1:0]  en_all,
    input  logic [NP-1:0][BW-1:0]  pend,
    input  logic [DW-1:0]          summary,
    output logic [NG-1:0]          set_we,
    output logic [NG-1:0]          clr_we,
    output logic [DW-1:0]          rdata
);

    // Per-group write strobes at base plus four bytes per group.
    for (genvar g = 0; g < NG; g++) begin : g_dec
        assign set_we[g] = bus_wr && (bus_addr == AW'(OFF_ENSET + 4 * g));
        assign clr_we[g] = bus_wr && (bus_addr == AW'(OFF_ENCLR + 4 * g));
    end

    // Read mux: summary, bank pending words, masks at both set and clear.
    always_comb begin
        rdata = '0;
        if (bus_addr == AW'(OFF_SUMMARY)) begin
            rdata = summary;
        end
        for (int p = 0; p < NP; p++) begin
            if (bus_addr == AW'(OFF_PEND + 4 * p)) begin
                rdata = DW'(pend[p]);
            end
        end
        for (int g = 0; g < NG; g++) begin
            if (bus_addr == AW'(OFF_ENSET + 4 * g) ||
                bus_addr == AW'(OFF_ENCLR + 4 * g)) begin
                rdata = en_all[g];
            end
        end
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
// Module banked_irq_ctrl
// Top of the banked level-sensitive interrupt controller: mask groups for two
// peripheral banks and the basic lines, masked pending words, summary word,
// register port and one registered interrupt request.
// Assumes all inputs are synchronous to clk and level-sensitive.
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PERIPH*BANK_W-1:0] src_bank,
    input  logic [BASIC_W-1:0]         src_basic,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq
);

    logic [N_GRP-1:0]                set_we;
    logic [N_GRP-1:0]                clr_we;
    logic [N_GRP-1:0][DATA_W-1:0]    en_all;
    logic [N_PERIPH-1:0][BANK_W-1:0] pend;
    logic [BASIC_W-1:0]              basic_m;
    logic [DATA_W-1:0]               summary_w;
    logic                            any_act;
    logic                            irq_q;

    // One mask group per bank plus one for the basic lines.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        if (g < N_PERIPH) begin : g_bank
            logic [BANK_W-1:0] en_b;
            irqc_enable_reg #(.W(BANK_W)) u_en (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_we (set_we[g]),
                .clr_we (clr_we[g]),
                .wdata  (bus_wdata[BANK_W-1:0]),
                .en_q   (en_b)
            );
            assign en_all[g] = DATA_W'(en_b);
            assign pend[g]   = src_bank[g*BANK_W +: BANK_W] & en_b;
        end else begin : g_basic
            logic [BASIC_W-1:0] en_s;
            irqc_enable_reg #(.W(BASIC_W)) u_en (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_we (set_we[g]),
                .clr_we (clr_we[g]),
                .wdata  (bus_wdata[BASIC_W-1:0]),
                .en_q   (en_s)
            );
            assign en_all[g] = DATA_W'(en_s);
            assign basic_m   = src_basic & en_s;
        end
    end

    // Summary word from masked lines.
    irqc_summary #(.BW(BANK_W), .SW(BASIC_W), .DW(DATA_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .basic_m (basic_m),
        .pend_a  (pend[0]),
        .pend_b  (pend[1]),
        .summary (summary_w)
    );

    // Address decode and read mux.
    irqc_regif #(.AW(ADDR_W), .DW(DATA_W), .BW(BANK_W),
                 .NG(N_GRP), .NP(N_PERIPH)) u_rif (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .en_all   (en_all),
        .pend     (pend),
        .summary  (summary_w),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .rdata    (bus_rdata)
    );

    // Any masked line across all groups.
    assign any_act = (|pend) || (|basic_m);

    // Register the request once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_act;
        end
    end

    assign irq = irq_q;

    // R10: the request mirrors the previous cycle's summary being non-zero.
    a_r10_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(summary_w != '0));

    // R1: no request in the first cycle after reset.
    a_r1_irq_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

endmodule

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;
    localparam logic [7:0] A_SUM  = 8'h00;
    localparam logic [7:0] A_PA   = 8'h04;
    localparam logic [7:0] A_PB   = 8'h08;
    localparam logic [7:0] A_SETA = 8'h10;
    localparam logic [7:0] A_SETB = 8'h14;
    localparam logic [7:0] A_SETS = 8'h18;
    localparam logic [7:0] A_CLRA = 8'h20;
    localparam logic [7:0] A_CLRB = 8'h24;
    localparam logic [7:0] A_CLRS = 8'h28;

    localparam logic [31:0] EN_A = 32'h000C_F288;
    localparam logic [31:0] EN_B = 32'h43E0_0003;
    localparam logic [7:0]  EN_S = 8'h0F;

    // Vector: {bank A lines, bank B lines, basic lines, expected irq}
    localparam int NV = 10;
    localparam logic [72:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 8'h00, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 8'hF0, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 8'h01, 1'b1},
        {32'h0000_0001, 32'h0000_0000, 8'h00, 1'b0},
        {32'h0000_0008, 32'h0000_0000, 8'h00, 1'b1},
        {32'h0000_0000, 32'h0000_0004, 8'h00, 1'b0},
        {32'h0000_0000, 32'h4000_0000, 8'h00, 1'b1},
        {32'h0000_1000, 32'h0000_0000, 8'h00, 1'b1},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 1'b1},
        {32'hFFF3_0D77, 32'hBC1F_FFFC, 8'hF0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_bank = '0;
    logic [7:0]  src_basic = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    banked_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_bank(src_bank), .src_basic(src_basic),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_SUM; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Summary word built from the requirements (R6-R9).
    function automatic logic [31:0] model_sum(input logic [31:0] a, input logic [31:0] b,
                                              input logic [7:0] s);
        logic [31:0] ma, mb, r;
        ma = a & EN_A; mb = b & EN_B; r = '0;
        r[7:0] = s & EN_S;
        r[8] = |ma; r[9] = |mb;
        r[10] = ma[3]; r[11] = ma[7]; r[12] = ma[9]; r[13] = ma[18]; r[14] = ma[19];
        r[15] = mb[21]; r[16] = mb[22]; r[17] = mb[23]; r[18] = mb[24];
        r[19] = mb[25]; r[20] = mb[30];
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        // R1: reset with every line active
        src_bank = '1; src_basic = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(A_SETA, d); check("R1 mask A", d, 32'h0);
        rd(A_CLRB, d); check("R1 mask B", d, 32'h0);
        rd(A_SETS, d); check("R1 mask basic", d, 32'h0);
        rd(A_SUM, d);  check("R1 summary", d, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2: set with zeros leaving bits alone, R4 read at both addresses
        wr(A_SETA, 32'h0000_00F0);
        wr(A_SETA, 32'h0000_000F);
        rd(A_SETA, d); check("R2 set accumulates", d, 32'h0000_00FF);
        rd(A_CLRA, d); check("R4 mask at clear addr", d, 32'h0000_00FF);
        // R3: clear ones, zeros keep
        wr(A_CLRA, 32'h0000_0005);
        rd(A_SETA, d); check("R3 clear ones", d, 32'h0000_00FA);
        wr(A_CLRA, 32'h0);
        rd(A_SETA, d); check("R3 clear zero keeps", d, 32'h0000_00FA);
        // R11: writes to read-only and unmapped addresses
        wr(A_SUM, 32'hFFFF_FFFF);
        wr(A_PA, 32'hFFFF_FFFF);
        wr(A_PB, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(A_SETA, d); check("R11 mask A kept", d, 32'h0000_00FA);
        rd(A_SETB, d); check("R11 mask B kept", d, 32'h0);
        rd(A_SETS, d); check("R11 mask basic kept", d, 32'h0);
        rd(8'h3C, d);  check("R11 unmapped reads 0", d, 32'h0);
        wr(A_CLRA, 32'hFFFF_FFFF);
        rd(A_CLRA, d); check("R3 clear all", d, 32'h0);

        // Program the masks for the vector walk
        wr(A_SETA, EN_A);
        wr(A_SETB, EN_B);
        wr(A_SETS, 32'hFFFF_FF0F);
        rd(A_CLRS, d); check("R4 basic mask width", d, {24'h0, EN_S});
        rd(A_CLRB, d); check("R4 mask B", d, EN_B);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] va, vb;
            logic [7:0]  vs;
            logic        vi;
            {va, vb, vs, vi} = VEC[i];
            @(negedge clk);
            src_bank = {vb, va}; src_basic = vs;
            rd(A_SUM, d); check($sformatf("R6 R7 R8 R9 summary vec %0d", i), d, model_sum(va, vb, vs));
            rd(A_PA, d);  check($sformatf("R5 pending A vec %0d", i), d, va & EN_A);
            rd(A_PB, d);  check($sformatf("R5 pending B vec %0d", i), d, vb & EN_B);
            check($sformatf("R10 irq vec %0d", i), {31'h0, irq}, {31'h0, vi});
        end

        // R10: one-cycle latency on rise and fall; R5 no latching
        @(negedge clk);
        src_bank = '0; src_basic = '0;
        repeat (2) @(negedge clk);
        src_bank = 64'h0000_0000_0000_0008;
        #1; check("R10 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq after one edge", {31'h0, irq}, 32'h1);
        src_bank = '0;
        #1; check("R10 irq still high", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R10 irq dropped", {31'h0, irq}, 32'h0);
        rd(A_PA, d); check("R5 no latching", d, 32'h0);
        rd(A_SUM, d); check("R9 idle summary", d, 32'h0);

        // R9: upper summary bits stay zero with everything on
        @(negedge clk);
        src_bank = '1; src_basic = '1;
        rd(A_SUM, d); check("R9 upper bits", d & 32'hFFE0_0000, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule